// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Selectable Holding Depth

The block turns bytes handed over by a host into asynchronous serial frames on a single output line. A host write is accepted into a holding store. The shift engine draws from that store whenever it is idle, or at the close of the current frame's last stop bit. The store is either a single holding slot or a 32-entry first-in-first-out queue. A level on a mode input selects which one is used, and any change of that level discards the bytes that are still waiting.

Bit timing comes from an external oversampling tick. Each serial bit lasts 16, 8 or 4 of those ticks, as selected. Frame shape is set by inputs: 5 to 8 data bits, optional even or odd parity, and one or two stop bits. Two status levels are reported: one says no byte is waiting, and the other says the shift engine is quiet. An interrupt can be raised when the holding store drains. It is cleared by an explicit clear strobe or by a new accepted write.

Top module: `serial_tx_fifo`

## Requirements
- R1: After reset, and whenever no frame is being shifted, `tx_o` is 1, `shift_empty_o` is 1, and after reset `hold_empty_o` is 1 and `irq_o` is 0.
- R2: A frame is a low start bit, then the data bits least significant first, then a parity bit when `par_en_i` is 1, then one stop bit (two when `two_stop_i` is 1) at level high. The number of data bits is 5 + `len_code_i` (0→5, 3→8). The parity bit makes the count of ones over data and parity even when `par_odd_i` is 0, and odd when it is 1.
- R3: Each bit lasts a fixed number of `os_tick_i` pulses: `os_rate_i` 1 gives 8, 2 gives 4, and 0 or 3 gives 16. The start bit's count begins at the load.
- R4: With `fifo_en_i` at 1, up to 32 bytes wait in write order. A write made while 32 are waiting and none leaves in that cycle is dropped.
- R5: With `fifo_en_i` at 0, one byte can wait. A write made while it is occupied, with no transfer in that cycle, is dropped.
- R6: `hold_empty_o` goes 0 in the cycle after an accepted write. It returns to 1 in the cycle after the last waiting byte moves into the shift register.
- R7: `shift_empty_o` goes 0 in the cycle after a byte is loaded into the shift register. It returns to 1 only after the final stop bit has run its full length.
- R8: When a byte is waiting at the end of the final stop bit, the next start bit follows with no idle time. A burst of n frames of b bits each at t ticks per bit, with a tick every cycle, keeps `shift_empty_o` low for exactly n*b*t cycles.
- R9: An interrupt becomes pending when a transfer into the shift register leaves the holding store empty while `irq_en_i` is 1. `irq_o` is that pending state gated by `irq_en_i`. `irq_clr_i` or an accepted write clears it.
- R10: A change of `fifo_en_i` discards every waiting byte, so `hold_empty_o` reads 1 at once. A frame already in the shift register still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| os_tick_i | input | 1 | Oversampling tick pulse |
| os_rate_i | input | 2 | Ticks per bit select: 1→8, 2→4, else 16 |
| fifo_en_i | input | 1 | 1 selects the 32-entry queue, 0 the single slot |
| wr_en_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| len_code_i | input | 2 | Data bits minus 5 |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 odd parity, 0 even |
| two_stop_i | input | 1 | Two stop bits when 1 |
| irq_en_i | input | 1 | Interrupt enable for holding-empty |
| irq_clr_i | input | 1 | Clears a pending interrupt |
| tx_o | output | 1 | Serial line, idles high |
| hold_empty_o | output | 1 | No byte waiting |
| shift_empty_o | output | 1 | Shift engine idle |
| irq_o | output | 1 | Holding-empty interrupt |

## Verification
The frame decoder is driven with several shapes: eight bits with even parity and two stops, seven bits with odd parity on a tick every third cycle, and five bits with the upper byte bits set. Together these show whether the bit order, the parity sense, the length masking and the stop count are correct. Bursts of writes are timed against the exact back-to-back duration, which exposes any idle gap, and the rate code 3 is covered by the same timing check. Writes past capacity in both modes, a mode flip with bytes waiting, and the interrupt raised with the enable on and off show the capacity, discard and masking behaviour. Each of these cases yields a frame stream or a flag level that is different from what a correct design produces.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/stx_buffer.sv
module stx_buffer #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             empty_o,
  output logic             accept_o,
  output logic             drain_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] CAP_Q = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q, cap;
  logic             mode_q, flush, full, pop_ok;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST_P) ? '0 : p + PW'(1);
  endfunction

  assign flush     = fifo_en_i ^ mode_q;
  assign cap       = fifo_en_i ? CAP_Q : ONE_C;
  assign full      = count_q >= cap;
  assign empty_o   = (count_q == '0) || flush;
  assign pop_ok    = pop_i && !empty_o;
  assign accept_o  = wr_i && !flush && (!full || pop_ok);
  assign drain_o   = pop_ok && (count_q == ONE_C) && !accept_o;
  assign rd_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      mode_q   <= 1'b0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      mode_q   <= fifo_en_i;
    end else begin
      if (accept_o) wr_ptr_q <= step(wr_ptr_q);
      if (pop_ok)   rd_ptr_q <= step(rd_ptr_q);
      case ({accept_o, pop_ok})
        2'b10:   count_q <= count_q + ONE_C;
        2'b01:   count_q <= count_q - ONE_C;
        default: count_q <= count_q;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i) begin
      if (accept_o && (wr_ptr_q == PW'(g))) mem_q[g] <= wr_data_i;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CAP_Q);
  assert_single_slot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |-> count_q <= ONE_C);
  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush |=> count_q == '0);
endmodule

// File: rtl/stx_bit_timer.sv
module stx_bit_timer #(
  parameter int unsigned MAX_TICKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] rate_i,
  output logic       bit_end_o
);
  localparam int unsigned CW = $clog2(MAX_TICKS);

  logic [CW-1:0] cnt_q, limit;

  always_comb begin
    case (rate_i)
      2'd1:    limit = CW'(MAX_TICKS / 2 - 1);
      2'd2:    limit = CW'(MAX_TICKS / 4 - 1);
      default: limit = CW'(MAX_TICKS - 1);
    endcase
  end

  assign bit_end_o = run_i && tick_i && (cnt_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (bit_end_o) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + CW'(1);
  end

  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> cnt_q == '0);
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  frame_cfg_t       cfg_i,
  input  logic             empty_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             bit_end_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             tx_o
);
  localparam int unsigned IW = $clog2(WIDTH);

  tx_state_e        state_q;
  logic [WIDTH-1:0] sreg_q;
  logic [IW-1:0]    idx_q, last_idx;
  logic             par_q, stop2_q, last_stop;

  assign last_idx  = IW'(WIDTH - 4) + IW'(cfg_i.len_code);
  assign last_stop = !cfg_i.two_stop || stop2_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign pop_o     = !empty_i && ((state_q == ST_IDLE) ||
                     ((state_q == ST_STOP) && bit_end_i && last_stop));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sreg_q  <= '0;
      idx_q   <= '0;
      par_q   <= 1'b0;
      stop2_q <= 1'b0;
    end else if (pop_o) begin
      state_q <= ST_START;
      sreg_q  <= data_i;
      par_q   <= cfg_i.par_odd;
    end else if (bit_end_i) begin
      case (state_q)
        ST_START: begin
          state_q <= ST_DATA;
          idx_q   <= '0;
        end
        ST_DATA: begin
          par_q  <= par_q ^ sreg_q[0];
          sreg_q <= sreg_q >> 1;
          if (idx_q == last_idx) begin
            state_q <= cfg_i.par_en ? ST_PARITY : ST_STOP;
            stop2_q <= 1'b0;
          end else begin
            idx_q <= idx_q + IW'(1);
          end
        end
        ST_PARITY: begin
          state_q <= ST_STOP;
          stop2_q <= 1'b0;
        end
        ST_STOP: begin
          if (!last_stop) stop2_q <= 1'b1;
          else            state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_START:  tx_o = 1'b0;
      ST_DATA:   tx_o = sreg_q[0];
      ST_PARITY: tx_o = par_q;
      default:   tx_o = 1'b1;
    endcase
  end

  assert_load_starts_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (state_q == ST_START) && !tx_o);
  assert_ends_in_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && $past(state_q != ST_IDLE)) |-> $past(state_q == ST_STOP));
endmodule

// File: rtl/serial_tx_fifo.sv
module serial_tx_fifo
  import stx_pkg::*;
#(
  parameter int unsigned DEPTH     = 32,
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned MAX_TICKS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             os_tick_i,
  input  logic [1:0]       os_rate_i,
  input  logic             fifo_en_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic [1:0]       len_code_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic             two_stop_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic             tx_o,
  output logic             hold_empty_o,
  output logic             shift_empty_o,
  output logic             irq_o
);
  frame_cfg_t       cfg;
  logic [WIDTH-1:0] rd_data;
  logic             empty, pop, accept, drain, busy, bit_end, irq_pend_q;

  assign cfg = '{len_code: len_code_i, par_en: par_en_i,
                 par_odd: par_odd_i, two_stop: two_stop_i};

  stx_buffer #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_buffer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fifo_en_i (fifo_en_i),
    .wr_i      (wr_en_i),
    .wr_data_i (wr_data_i),
    .pop_i     (pop),
    .rd_data_o (rd_data),
    .empty_o   (empty),
    .accept_o  (accept),
    .drain_o   (drain)
  );

  stx_bit_timer #(.MAX_TICKS(MAX_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (busy),
    .tick_i    (os_tick_i),
    .rate_i    (os_rate_i),
    .bit_end_o (bit_end)
  );

  stx_shifter #(.WIDTH(WIDTH)) u_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .empty_i   (empty),
    .data_i    (rd_data),
    .bit_end_i (bit_end),
    .pop_o     (pop),
    .busy_o    (busy),
    .tx_o      (tx_o)
  );

  // a new drain event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   irq_pend_q <= 1'b0;
    else if (drain && irq_en_i)    irq_pend_q <= 1'b1;
    else if (irq_clr_i || accept)  irq_pend_q <= 1'b0;
  end

  assign hold_empty_o  = empty;
  assign shift_empty_o = !busy;
  assign irq_o         = irq_pend_q && irq_en_i;

  assert_idle_line_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_empty_o |-> tx_o);
  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pend_q) |-> hold_empty_o && !shift_empty_o);
  assert_write_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !drain) |=> !irq_o);
endmodule

// File: tb/serial_tx_fifo_tb_top.sv
`timescale 1ns/1ps
module serial_tx_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic [1:0] os_rate = 2'd0;
  logic       fifo_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] len_code = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       two_stop = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq_clr = 1'b0;
  logic       tx, hold_empty, shift_empty, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_period = 1;
  int tph = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];

  bit meas_on = 0, m_low = 0, m_idle = 0;
  int t0 = 0, t1 = 0;

  always #4 clk = ~clk;

  serial_tx_fifo dut_i (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(os_tick), .os_rate_i(os_rate),
    .fifo_en_i(fifo_en), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .len_code_i(len_code), .par_en_i(par_en), .par_odd_i(par_odd),
    .two_stop_i(two_stop), .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .tx_o(tx), .hold_empty_o(hold_empty), .shift_empty_o(shift_empty), .irq_o(irq)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    tph = (tph + 1 >= tick_period) ? 0 : tph + 1;
    os_tick = (tph == 0);
  end

  always @(negedge clk) begin
    if (meas_on) begin
      if (!m_low && !tx) begin
        m_low = 1; t0 = cyc;
      end else if (m_low && !m_idle && shift_empty) begin
        m_idle = 1; t1 = cyc;
      end
    end
  end

  function automatic int tpb(input logic [1:0] r);
    case (r)
      2'd1:    return 8;
      2'd2:    return 4;
      default: return 16;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input bit kept);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    if (kept) exp_q.push_back(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(shift_empty && hold_empty));
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected frames seen", exp_q.size(), 0);
    chk(tx == 1'b1, "R1 line high when idle", tx, 1);
  endtask

  task automatic start_meas();
    m_low = 0; m_idle = 0; meas_on = 1;
  endtask

  // monitor: decodes frames and compares against the scoreboard queue
  initial begin : monitor
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && prev && !tx) begin
        int bc, nb;
        logic [7:0] got, e;
        logic pb, pexp, bad;
        bc = tpb(os_rate) * tick_period;
        nb = 5 + int'(len_code);
        got = 8'h00;
        bad = 1'b0;
        pb = 1'b0;
        repeat (bc / 2 - 1) @(negedge clk);
        if (tx) bad = 1'b1;
        for (int i = 0; i < nb; i++) begin
          repeat (bc) @(negedge clk);
          got[i] = tx;
        end
        if (par_en) begin
          repeat (bc) @(negedge clk);
          pb = tx;
        end
        repeat (bc) @(negedge clk);
        if (!tx) bad = 1'b1;
        if (two_stop) begin
          repeat (bc) @(negedge clk);
          if (!tx) bad = 1'b1;
        end
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected frame", got, 0);
        end else begin
          e = exp_q.pop_front() & 8'((1 << nb) - 1);
          chk(got == e && !bad, "R2 frame data/start/stop", {bad, got}, e);
          if (par_en) begin
            pexp = (^e) ^ par_odd;
            chk(pb == pexp, "R2 parity bit", pb, pexp);
          end
        end
        prev = 1'b1;
      end else begin
        prev = tx;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx == 1'b1, "R1 reset line", tx, 1);
    chk(hold_empty == 1'b1, "R1 reset hold_empty", hold_empty, 1);
    chk(shift_empty == 1'b1, "R1 reset shift_empty", shift_empty, 1);
    chk(irq == 1'b0, "R1 reset irq", irq, 0);

    // single slot, 8N1, 16x, flag timing and interrupt
    irq_en = 1'b1;
    wr(8'hA5, 1);
    chk(hold_empty == 1'b0, "R6 hold_empty falls after write", hold_empty, 0);
    chk(shift_empty == 1'b1, "R7 shifter still idle", shift_empty, 1);
    @(negedge clk);
    chk(hold_empty == 1'b1, "R6 hold_empty rises on transfer", hold_empty, 1);
    chk(shift_empty == 1'b0, "R7 shift_empty falls on load", shift_empty, 0);
    chk(irq == 1'b1, "R9 irq on drain", irq, 1);
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b0, "R9 clear strobe", irq, 0);
    wr(8'h3C, 1);
    chk(hold_empty == 1'b0, "R6 waiting byte", hold_empty, 0);
    do @(negedge clk); while (!hold_empty);
    chk(irq == 1'b1, "R9 irq on second drain", irq, 1);
    chk(shift_empty == 1'b0, "R8 next frame loaded at once", shift_empty, 0);
    wr(8'h81, 1);
    chk(irq == 1'b0, "R9 write clears irq", irq, 0);
    wr(8'h7E, 0);
    chk(hold_empty == 1'b0, "R5 slot still occupied", hold_empty, 0);
    wait_idle();

    // interrupt masked
    irq_en = 1'b0;
    wr(8'h11, 1);
    wait_idle();
    chk(irq == 1'b0, "R9 no irq when disabled", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R9 no latent irq after enable", irq, 0);
    irq_en = 1'b0;

    // 8E2 at 8x, FIFO burst, no gaps
    fifo_en = 1'b1; os_rate = 2'd1; par_en = 1'b1; par_odd = 1'b0; two_stop = 1'b1;
    repeat (2) @(negedge clk);
    start_meas();
    for (int i = 0; i < 6; i++) wr(8'(i * 37 + 5), 1);
    wait_idle();
    meas_on = 0;
    chk(t1 - t0 == 6 * 12 * 8, "R8 burst duration", t1 - t0, 6 * 12 * 8);

    // 7O1 at 4x, tick every third cycle
    len_code = 2'd2; par_odd = 1'b1; two_stop = 1'b0; os_rate = 2'd2; tick_period = 3;
    repeat (2) @(negedge clk);
    wr(8'h55, 1); wr(8'hF0, 1); wr(8'h01, 1);
    wait_idle();

    // 5N1, rate code 3, upper bits masked
    len_code = 2'd0; par_en = 1'b0; os_rate = 2'd3; tick_period = 1;
    repeat (2) @(negedge clk);
    start_meas();
    wr(8'hFF, 1);
    wait_idle();
    meas_on = 0;
    chk(t1 - t0 == 7 * 16, "R3 rate 3 gives 16 ticks", t1 - t0, 7 * 16);

    // FIFO overflow, 8N1 16x
    len_code = 2'd3; os_rate = 2'd0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 33; i++) wr(8'(i * 7 + 3), 1);
    chk(hold_empty == 1'b0, "R4 queue full", hold_empty, 0);
    wr(8'hEE, 0); wr(8'hDD, 0);
    wait_idle();

    // mode change discards waiting bytes
    wr(8'h96, 1); wr(8'h12, 0); wr(8'h34, 0);
    @(negedge clk); fifo_en = 1'b0;
    @(negedge clk);
    chk(hold_empty == 1'b1, "R10 flush on mode change", hold_empty, 1);
    chk(shift_empty == 1'b0, "R10 current frame continues", shift_empty, 0);
    wait_idle();

    // single slot overflow
    wr(8'hC3, 1); wr(8'h5A, 1); wr(8'h99, 0);
    chk(hold_empty == 1'b0, "R5 slot holds one", hold_empty, 0);
    wait_idle();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule